// File: doc/BRIEF.md
# Codec Control Register Shadow Manager

This block sits between a host that issues field-level codec configuration commands and a serial writer that ships complete codec register words. Each command names one bit field, such as DAC power, word length, data format or the sample-rate code, and carries a small argument. The block looks up its local shadow copy of the register that holds the field. It replaces only that field and offers the whole 9-bit word, with the register's 7-bit address, to the writer through a valid/ready handshake.

The shadow copy changes only in the cycle the writer accepts the word. A later command to the same register therefore builds on every field that was written before. An argument out of range, or an unknown command code, raises a one-cycle error pulse. In that case no write is made and the shadows stay as they were. Only one command can be in flight at a time: the block drops `cmd_ready` while a write is pending.

Top module: `codec_ctl_shadow`

## Requirements
- R1: In the cycle after synchronous reset, `wr_valid` and `err` are 0 and `cmd_ready` is 1. The shadows hold their defaults: power-down 0x0FF, digital path 0x008, format 0x001, sample rate 0x020, activation 0x000. The reset command word is 0x000.
- R2: Power commands target address 6. Ops 0..5 map to bits 7 (device), 6 (clock), 5 (oscillator), 4 (outputs), 3 (DAC) and 0 (line input). Argument 1 clears the bit (function on) and argument 0 sets it (function off).
- R3: Op 6 writes the argument, 0..3, into bits 2:1 of the digital-path register at address 5. Code 2 means 44.1 kHz and code 3 means 48 kHz. An argument above 3 is an error.
- R4: At address 7, op 7 sets bit 6 (1 = master), op 8 sets bit 5 (left/right swap) and op 9 sets bit 4 (left/right phase). Each takes the argument's value.
- R5: Op 10 takes a word length of 16, 20, 24 or 32 and writes 0, 1, 2 or 3 into bits 3:2 of address 7. Any other length is an error.
- R6: Op 11 writes the argument into bits 1:0 of address 7: 0 right-justified, 1 left-justified, 2 I2S, 3 DSP. An argument above 3 is an error.
- R7: At address 8, op 12 sets bit 7 (output clock halved) and op 13 sets bit 6 (input clock halved). Op 14 writes a rate code of 0..15 into bits 5:2. Op 15 sets bit 1 (base oversampling) and op 16 sets bit 0 (USB clock mode). A rate code above 15 is an error.
- R8: Op 17 sets bit 0 of address 9 (interface active). Op 18 with argument 1 sends the reset value to address 15. Op 18 with any other argument is an error.
- R9: An accepted command that is illegal pulses `err` for exactly one cycle, one cycle after acceptance. It issues no write and leaves every shadow unchanged. Illegal means a boolean argument other than 0 or 1, an argument out of range, or an op above 18.
- R10: `wr_valid` rises one cycle after a legal command is accepted. It stays high, with `wr_addr` and `wr_data` stable, until `wr_ready` is seen, and it falls in the following cycle.
- R11: The shadow commits in the handshake cycle. A later command to the same register changes only its own field and keeps every field written before.
- R12: While a write is pending, `cmd_ready` is 0. A command presented then is ignored: it raises no error and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 5 | Command code (field selector) |
| cmd_arg | input | 6 | Command argument |
| err | output | 1 | One-cycle pulse for an illegal command |
| wr_valid | output | 1 | Register write offered to the serial writer |
| wr_ready | input | 1 | Serial writer accepts the word |
| wr_addr | output | 7 | Codec register address |
| wr_data | output | 9 | Full register value |

## Verification
A wrong shadow stays hidden until the next command that targets the same register. That command's write word then carries the corrupted neighbouring bits, one cycle after it is accepted. For this reason the bench chains several commands per register and checks whole words, not single fields. An error command that leaks into a shadow shows up the same way at the next legal write. A handshake fault shows at once: a dropped or changing `wr_valid` during a stall, or a second write appearing after a command that should have been ignored.

// File: rtl/codec_ctl_shadow.sv
module codec_ctl_shadow #(
  parameter logic [6:0] ADDR_PWR  = 7'd6,
  parameter logic [6:0] ADDR_PATH = 7'd5,
  parameter logic [6:0] ADDR_FMT  = 7'd7,
  parameter logic [6:0] ADDR_RATE = 7'd8,
  parameter logic [6:0] ADDR_ACT  = 7'd9,
  parameter logic [6:0] ADDR_RST  = 7'd15,
  parameter logic [8:0] DEF_PWR   = 9'h0FF,
  parameter logic [8:0] DEF_PATH  = 9'h008,
  parameter logic [8:0] DEF_FMT   = 9'h001,
  parameter logic [8:0] DEF_RATE  = 9'h020,
  parameter logic [8:0] DEF_ACT   = 9'h000,
  parameter logic [8:0] RST_WORD  = 9'h000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [4:0] cmd_op,
  input  logic [5:0] cmd_arg,
  output logic       err,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [6:0] wr_addr,
  output logic [8:0] wr_data
);
  localparam int NREG = 5;
  localparam int SW   = $clog2(NREG + 1);
  localparam logic [SW-1:0] S_PWR = 0, S_PATH = 1, S_FMT = 2, S_RATE = 3, S_ACT = 4, S_RST = 5;

  logic [8:0]    shadow [NREG];
  logic [SW-1:0] sel, pend_sel;
  logic [8:0]    mask, fval, cur, next_word;
  logic [6:0]    addr;
  logic          legal, raw, take, bool_ok;

  assign cmd_ready = !wr_valid;
  assign take      = cmd_valid && cmd_ready;
  assign bool_ok   = cmd_arg[5:1] == '0;
  assign cur       = (sel == S_RST) ? RST_WORD : shadow[sel];
  assign next_word = raw ? RST_WORD : ((cur & ~mask) | (fval & mask));

  always_comb begin
    sel   = S_PWR;
    mask  = '0;
    fval  = '0;
    legal = bool_ok;
    raw   = 1'b0;
    case (cmd_op)
      5'd0:  begin mask = 9'h080; fval = {9{~cmd_arg[0]}}; end
      5'd1:  begin mask = 9'h040; fval = {9{~cmd_arg[0]}}; end
      5'd2:  begin mask = 9'h020; fval = {9{~cmd_arg[0]}}; end
      5'd3:  begin mask = 9'h010; fval = {9{~cmd_arg[0]}}; end
      5'd4:  begin mask = 9'h008; fval = {9{~cmd_arg[0]}}; end
      5'd5:  begin mask = 9'h001; fval = {9{~cmd_arg[0]}}; end
      5'd6:  begin
        sel = S_PATH; mask = 9'h006; fval = {6'b0, cmd_arg[1:0], 1'b0};
        legal = cmd_arg[5:2] == '0;
      end
      5'd7:  begin sel = S_FMT; mask = 9'h040; fval = {9{cmd_arg[0]}}; end
      5'd8:  begin sel = S_FMT; mask = 9'h020; fval = {9{cmd_arg[0]}}; end
      5'd9:  begin sel = S_FMT; mask = 9'h010; fval = {9{cmd_arg[0]}}; end
      5'd10: begin
        sel = S_FMT; mask = 9'h00C;
        case (cmd_arg)
          6'd16:   begin fval = 9'h000; legal = 1'b1; end
          6'd20:   begin fval = 9'h004; legal = 1'b1; end
          6'd24:   begin fval = 9'h008; legal = 1'b1; end
          6'd32:   begin fval = 9'h00C; legal = 1'b1; end
          default: legal = 1'b0;
        endcase
      end
      5'd11: begin
        sel = S_FMT; mask = 9'h003; fval = {7'b0, cmd_arg[1:0]};
        legal = cmd_arg[5:2] == '0;
      end
      5'd12: begin sel = S_RATE; mask = 9'h080; fval = {9{cmd_arg[0]}}; end
      5'd13: begin sel = S_RATE; mask = 9'h040; fval = {9{cmd_arg[0]}}; end
      5'd14: begin
        sel = S_RATE; mask = 9'h03C; fval = {3'b0, cmd_arg[3:0], 2'b0};
        legal = cmd_arg[5:4] == '0;
      end
      5'd15: begin sel = S_RATE; mask = 9'h002; fval = {9{cmd_arg[0]}}; end
      5'd16: begin sel = S_RATE; mask = 9'h001; fval = {9{cmd_arg[0]}}; end
      5'd17: begin sel = S_ACT;  mask = 9'h001; fval = {9{cmd_arg[0]}}; end
      5'd18: begin sel = S_RST; raw = 1'b1; legal = cmd_arg == 6'd1; end
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    case (sel)
      S_PWR:   addr = ADDR_PWR;
      S_PATH:  addr = ADDR_PATH;
      S_FMT:   addr = ADDR_FMT;
      S_RATE:  addr = ADDR_RATE;
      S_ACT:   addr = ADDR_ACT;
      default: addr = ADDR_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      err       <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      pend_sel  <= S_PWR;
      shadow[S_PWR]  <= DEF_PWR;
      shadow[S_PATH] <= DEF_PATH;
      shadow[S_FMT]  <= DEF_FMT;
      shadow[S_RATE] <= DEF_RATE;
      shadow[S_ACT]  <= DEF_ACT;
    end else begin
      err <= take && !legal;
      if (take && legal) begin
        wr_valid <= 1'b1;
        wr_addr  <= addr;
        wr_data  <= next_word;
        pend_sel <= sel;
      end else if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
        if (pend_sel != S_RST) shadow[pend_sel] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/codec_ctl_shadow_chk.sv
module codec_ctl_shadow_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       err,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [6:0] wr_addr,
  input logic [8:0] wr_data
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R10
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready |=> !wr_valid); // R10
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> !wr_valid && $past(cmd_valid)); // R9
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> !err); // R12
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err || $past(cmd_valid)); // R9
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_addr inside {7'd5, 7'd6, 7'd7, 7'd8, 7'd9, 7'd15}); // R8
endmodule

bind codec_ctl_shadow codec_ctl_shadow_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .err(err),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_codec_ctl_shadow.sv
module tb_codec_ctl_shadow;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [4:0] cmd_op = '0;
  logic [5:0] cmd_arg = '0;
  logic       err;
  logic       wr_valid;
  logic       wr_ready = 1'b0;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_ctl_shadow dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .err(err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [5:0] arg);
    @(negedge clk);
    cmd_op = op; cmd_arg = arg; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic good(input string req, input logic [4:0] op, input logic [5:0] arg,
                      input logic [6:0] ea, input logic [8:0] ed, input int stall);
    issue(op, arg);
    check(wr_valid === 1'b1 && err === 1'b0, req, "write offered", wr_valid, 1);
    check(wr_addr === ea, req, "address", wr_addr, ea);
    check(wr_data === ed, req, "data", wr_data, ed);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(wr_valid === 1'b1 && wr_data === ed && cmd_ready === 1'b0, "R10", "held during stall", wr_data, ed);
    end
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    check(wr_valid === 1'b0 && cmd_ready === 1'b1, "R10", "released after accept", wr_valid, 0);
  endtask

  task automatic bad(input string req, input logic [4:0] op, input logic [5:0] arg);
    issue(op, arg);
    check(err === 1'b1 && wr_valid === 1'b0, req, "error without write", {err, wr_valid}, 2);
    @(negedge clk);
    check(err === 1'b0 && wr_valid === 1'b0, "R9", "error pulse is one cycle", {err, wr_valid}, 0);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wr_valid === 1'b0 && err === 1'b0 && cmd_ready === 1'b1, "R1", "idle after reset",
          {wr_valid, err, cmd_ready}, 1);
  endtask

  task automatic t_power;
    good("R2", 5'd0, 6'd1, 7'd6, 9'h07F, 3);
    good("R11", 5'd4, 6'd1, 7'd6, 9'h077, 0);
    bad("R9", 5'd4, 6'd2);
    good("R9", 5'd5, 6'd1, 7'd6, 9'h076, 1);
    good("R2", 5'd1, 6'd1, 7'd6, 9'h036, 0);
    good("R2", 5'd2, 6'd1, 7'd6, 9'h016, 0);
    good("R2", 5'd3, 6'd1, 7'd6, 9'h006, 0);
    good("R2", 5'd4, 6'd0, 7'd6, 9'h00E, 2);
  endtask

  task automatic t_path;
    good("R3", 5'd6, 6'd3, 7'd5, 9'h00E, 0);
    good("R3", 5'd6, 6'd2, 7'd5, 9'h00C, 0);
    bad("R3", 5'd6, 6'd4);
  endtask

  task automatic t_format;
    good("R4", 5'd7, 6'd1, 7'd7, 9'h041, 0);
    good("R4", 5'd8, 6'd1, 7'd7, 9'h061, 0);
    good("R4", 5'd9, 6'd1, 7'd7, 9'h071, 0);
    good("R4", 5'd8, 6'd0, 7'd7, 9'h051, 0);
    good("R5", 5'd10, 6'd24, 7'd7, 9'h059, 0);
    good("R5", 5'd10, 6'd20, 7'd7, 9'h055, 0);
    bad("R5", 5'd10, 6'd18);
    good("R5", 5'd10, 6'd32, 7'd7, 9'h05D, 0);
    good("R6", 5'd11, 6'd2, 7'd7, 9'h05E, 0);
    good("R6", 5'd11, 6'd3, 7'd7, 9'h05F, 0);
    good("R6", 5'd11, 6'd0, 7'd7, 9'h05C, 0);
    bad("R6", 5'd11, 6'd4);
  endtask

  task automatic t_rate;
    good("R7", 5'd14, 6'd15, 7'd8, 9'h03C, 0);
    good("R7", 5'd12, 6'd1, 7'd8, 9'h0BC, 0);
    good("R7", 5'd13, 6'd1, 7'd8, 9'h0FC, 0);
    good("R7", 5'd15, 6'd1, 7'd8, 9'h0FE, 0);
    good("R7", 5'd16, 6'd1, 7'd8, 9'h0FF, 0);
    good("R7", 5'd14, 6'd5, 7'd8, 9'h0D7, 0);
    bad("R7", 5'd14, 6'd16);
  endtask

  task automatic t_misc;
    good("R8", 5'd17, 6'd1, 7'd9, 9'h001, 0);
    bad("R9", 5'd17, 6'd2);
    good("R8", 5'd18, 6'd1, 7'd15, 9'h000, 0);
    bad("R8", 5'd18, 6'd0);
    bad("R9", 5'd31, 6'd1);
  endtask

  task automatic t_busy;
    issue(5'd0, 6'd0);
    check(wr_valid === 1'b1 && wr_data === 9'h08E, "R12", "first write", wr_data, 9'h08E);
    cmd_op = 5'd5; cmd_arg = 6'd0; cmd_valid = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b0 && err === 1'b0, "R12", "not ready while pending", cmd_ready, 0);
    cmd_op = 5'd5; cmd_arg = 6'd7;
    @(negedge clk);
    check(err === 1'b0 && wr_data === 9'h08E, "R12", "busy command ignored", wr_data, 9'h08E);
    cmd_valid = 1'b0;
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    @(negedge clk);
    check(wr_valid === 1'b0 && err === 1'b0, "R12", "no second write", wr_valid, 0);
    good("R12", 5'd1, 6'd0, 7'd6, 9'h0CE, 0);
  endtask

  initial begin
    t_reset;
    t_power;
    t_path;
    t_format;
    t_rate;
    t_misc;
    t_busy;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule